// File: doc/BRIEF.md
# GPIO Change-Interrupt Controller with Modem Line Muxing

This block serves eight general-purpose pins on a two-channel serial bridge. A host reaches it through a flat register port with a 3-bit address, a write strobe and a read strobe. Reads return data combinationally in the same cycle. The block holds a direction, an output value and a change-enable bit for each pin, plus a control register. It watches every pin configured as an input and flags any level change against a stored reference. It drives one interrupt line that ORs every flagged and enabled pin.

The control register sets how input levels are captured. In transparent capture, a pin that returns to its reference level before the host reads withdraws its own interrupt. In latched capture, the first new level is frozen and the interrupt holds until the input-state register is read. Either nibble of pins can be handed to one serial channel as modem lines: ring indicator, carrier detect, a DTR output and DSR. In that role the pins report through a per-channel modem-status register, and their interrupt is gated by a per-channel modem enable rather than by the pin enables.

A write of the soft-reset control bit takes the control state machine from CTL_RUN into CTL_CLEAR for exactly one cycle, then back to CTL_RUN. Each pin has its own watch state machine with the states PW_IDLE, PW_LIVE and PW_HELD:
- PW_IDLE to PW_LIVE on a change in transparent capture.
- PW_IDLE to PW_HELD on a change in latched capture.
- PW_LIVE to PW_IDLE when the level returns to the reference.
- Either pending state to PW_IDLE on a read of the input-state register, unless a new change lands on that same edge.
- Any state to PW_IDLE when the pin stops being an eligible input or a soft reset runs.

Each modem channel has a state machine with the states MS_OFF (pins in I/O role), MS_QUIET (no delta pending) and MS_FLAGGED (one or more deltas pending).

Top module: `gpio_chg_ctl`

## Requirements
- R1: After reset every register address (0 to 7) reads 0x00, irq is 0 and pin_oe is 0x00.
- R2: In I/O role, pin_oe[i] equals direction bit i (address 0, 1 = output) and pin_out[i] equals output bit i, which is written at address 1.
- R3: A pin in I/O role with direction bit 0 whose synchronized level differs from its reference becomes pending. irq is the OR of the pending flags ANDed with the change-enable register (address 2), ORed with the modem interrupts. Pins with direction bit 1 never become pending. The reference resets to 0.
- R4: With control bit 0 (capture mode) at 0, a read of address 1 returns the live pin levels, clears all pending flags and loads the references. A pin that returns to its reference before that read stops being pending.
- R5: With control bit 0 at 1, the first change of a pin freezes its new level. A read of address 1 returns that frozen level for pending pins and clears them. A return to the reference before the read leaves the pin pending.
- R6: If a pin's synchronized level changes on the same clock edge as a read of address 1, the pin stays pending in the cycle after the read.
- R7: Control bit 1 gives pins 7:4 to channel A and control bit 2 gives pins 3:0 to channel B, with the same order in each nibble: bit 3 RI in, bit 2 CD in, bit 1 DTR out, bit 0 DSR in. In that role, the direction, output and change-enable bits have no effect, only the DTR pin is driven, and the pins never become pending.
- R8: The modem status of channel A is at address 4 and of channel B at address 5. The fields are: bit 7 CD level, bit 6 RI level, bit 5 DSR level, bit 3 CD changed, bit 2 RI changed, bit 1 DSR changed, and all other bits 0. A read clears the changed bits. The whole register reads 0 while the channel's nibble is in I/O role.
- R9: The modem configuration of channel A is at address 6 and of channel B at address 7. Bit 0 drives the DTR pin and bit 3 enables the channel's modem interrupt, which is the OR of its changed bits. All other bits read 0.
- R10: Writing control (address 3) with bit 3 set ignores the rest of that write. Control then reads bit 3 as 1 for one cycle, after which every register is 0. Control bits 7:4 always read 0.
- R11: A pin level change reaches irq on the third rising clock edge after it is applied, because of a two-stage input synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin output enables, 1 = drive |
| irq | output | 1 | Combined interrupt |

## Verification
Single-pin directed changes measure the synchronizer latency exactly and separate transparent withdrawal from latched hold. A change timed to land on the edge of an input-state read separates "change wins" from "read wins" in the very next cycle. Seeded random pin walks run against random directions, enables and capture modes, with random reads between them. The model's expected levels and interrupt then expose wrong masking, wrong frozen values and missed clears. Modem-role tests toggle each modem input with the pin enables set and the modem enable both off and on, which shows that the interrupt gating has moved to the modem enable.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
    localparam int PINS = 8;
    localparam int AW   = 3;

    typedef enum logic [AW-1:0] {
        A_DIR   = 3'd0,
        A_PINS  = 3'd1,
        A_CHGEN = 3'd2,
        A_CTRL  = 3'd3,
        A_MSR_A = 3'd4,
        A_MSR_B = 3'd5,
        A_MDM_A = 3'd6,
        A_MDM_B = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {PW_IDLE, PW_LIVE, PW_HELD} pw_state_e;
    typedef enum logic [1:0] {MS_OFF, MS_QUIET, MS_FLAGGED} ms_state_e;
    typedef enum logic {CTL_RUN, CTL_CLEAR} ctl_state_e;

    localparam int CTRL_LATCH = 0;
    localparam int CTRL_MDM_A = 1;
    localparam int CTRL_MDM_B = 2;
    localparam int CTRL_SRST  = 3;
endpackage

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) st[k] <= '0;
        end else begin
            st[0] <= d;
            for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
        end
    end

    assign q      = st[STAGES-1];
    assign q_next = st[STAGES-2];
endmodule

// File: rtl/gpio_chg_pinwatch.sv
module gpio_chg_pinwatch
    import gpio_chg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic eligible,
    input  logic latch_mode,
    input  logic lvl,
    input  logic lvl_next,
    input  logic rd_pins,
    output logic pending,
    output logic rd_val
);
    pw_state_e state_q, state_n;
    logic      ref_q, ref_n;
    logic      held_q, held_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PW_IDLE;
            ref_q   <= 1'b0;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            ref_q   <= ref_n;
            held_q  <= held_n;
        end
    end

    always_comb begin
        state_n = state_q;
        ref_n   = ref_q;
        held_n  = held_q;
        if (clr || !eligible) begin
            state_n = PW_IDLE;
            ref_n   = lvl;
        end else if (rd_pins) begin
            ref_n = lvl;
            if (lvl_next != lvl) begin
                state_n = latch_mode ? PW_HELD : PW_LIVE;
                held_n  = lvl_next;
            end else begin
                state_n = PW_IDLE;
            end
        end else begin
            unique case (state_q)
                PW_IDLE: begin
                    if (lvl != ref_q) begin
                        if (latch_mode) begin
                            state_n = PW_HELD;
                            held_n  = lvl;
                        end else begin
                            state_n = PW_LIVE;
                        end
                    end
                end
                PW_LIVE: begin
                    if (lvl == ref_q) state_n = PW_IDLE;
                end
                PW_HELD: state_n = PW_HELD;
                default: state_n = PW_IDLE;
            endcase
        end
    end

    always_comb begin
        pending = (state_q != PW_IDLE);
        rd_val  = (state_q == PW_HELD) ? held_q : lvl;
    end
endmodule

// File: rtl/gpio_chg_modem.sv
module gpio_chg_modem
    import gpio_chg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       mode,
    input  logic [2:0] lines,
    input  logic       rd_msr,
    output logic [7:0] msr,
    output logic       delta_any
);
    // lines: [2] CD, [1] RI, [0] DSR
    ms_state_e state_q, state_n;
    logic [2:0] prev_q;
    logic [2:0] dlt_q, dlt_n;
    logic [2:0] chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_OFF;
            prev_q  <= '0;
            dlt_q   <= '0;
        end else begin
            state_q <= state_n;
            prev_q  <= lines;
            dlt_q   <= dlt_n;
        end
    end

    assign chg = lines ^ prev_q;

    always_comb begin
        state_n = state_q;
        dlt_n   = dlt_q;
        if (clr || !mode) begin
            state_n = MS_OFF;
            dlt_n   = '0;
        end else begin
            unique case (state_q)
                MS_OFF:     dlt_n = '0;
                MS_QUIET:   dlt_n = chg;
                MS_FLAGGED: dlt_n = (rd_msr ? 3'b000 : dlt_q) | chg;
                default:    dlt_n = '0;
            endcase
            state_n = (dlt_n != 3'b000) ? MS_FLAGGED : MS_QUIET;
        end
    end

    always_comb begin
        if (state_q == MS_OFF) begin
            msr = 8'h00;
        end else begin
            msr = {lines[2], lines[1], lines[0], 1'b0, dlt_q[2], dlt_q[1], dlt_q[0], 1'b0};
        end
        delta_any = |dlt_q;
    end
endmodule

// File: rtl/gpio_chg_ctl.sv
module gpio_chg_ctl
    import gpio_chg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    output logic            irq
);
    localparam int HALF = PINS / 2;

    ctl_state_e ctl_q, ctl_n;
    logic srst;

    logic [PINS-1:0] dir_q, out_q, chgen_q;
    logic [2:0]      ctrl_q;
    logic [1:0]      mdm_a_q, mdm_b_q;   // [1] interrupt enable, [0] DTR

    logic [PINS-1:0] lvl, lvl_nx;
    logic [PINS-1:0] pend_w, rdv_w, io_role, elig;
    logic            rd_pins, rd_msr_a, rd_msr_b;
    logic [7:0]      msr_a, msr_b;
    logic            dlt_a, dlt_b;

    // soft reset control FSM: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RUN;
        else        ctl_q <= ctl_n;
    end

    always_comb begin
        ctl_n = ctl_q;
        unique case (ctl_q)
            CTL_RUN:   if (wr_en && addr == A_CTRL && wdata[CTRL_SRST]) ctl_n = CTL_CLEAR;
            CTL_CLEAR: ctl_n = CTL_RUN;
            default:   ctl_n = CTL_RUN;
        endcase
    end

    assign srst = (ctl_q == CTL_CLEAR);

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            out_q   <= '0;
            chgen_q <= '0;
            ctrl_q  <= '0;
            mdm_a_q <= '0;
            mdm_b_q <= '0;
        end else if (srst) begin
            dir_q   <= '0;
            out_q   <= '0;
            chgen_q <= '0;
            ctrl_q  <= '0;
            mdm_a_q <= '0;
            mdm_b_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_DIR:   dir_q   <= wdata;
                A_PINS:  out_q   <= wdata;
                A_CHGEN: chgen_q <= wdata;
                A_CTRL:  if (!wdata[CTRL_SRST]) ctrl_q <= wdata[2:0];
                A_MDM_A: mdm_a_q <= {wdata[3], wdata[0]};
                A_MDM_B: mdm_b_q <= {wdata[3], wdata[0]};
                default: ;
            endcase
        end
    end

    assign rd_pins  = rd_en && (addr == A_PINS)  && !srst;
    assign rd_msr_a = rd_en && (addr == A_MSR_A) && !srst;
    assign rd_msr_b = rd_en && (addr == A_MSR_B) && !srst;

    gpio_chg_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pin_in),
        .q      (lvl),
        .q_next (lvl_nx)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        if (i >= HALF) begin : g_hi
            assign io_role[i] = !ctrl_q[CTRL_MDM_A];
        end else begin : g_lo
            assign io_role[i] = !ctrl_q[CTRL_MDM_B];
        end
        assign elig[i] = io_role[i] && !dir_q[i];

        gpio_chg_pinwatch u_watch (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (srst),
            .eligible   (elig[i]),
            .latch_mode (ctrl_q[CTRL_LATCH]),
            .lvl        (lvl[i]),
            .lvl_next   (lvl_nx[i]),
            .rd_pins    (rd_pins),
            .pending    (pend_w[i]),
            .rd_val     (rdv_w[i])
        );

        if ((i % 4) == 1) begin : g_dtr
            logic dtr_val;
            assign dtr_val    = (i >= HALF) ? mdm_a_q[0] : mdm_b_q[0];
            assign pin_oe[i]  = io_role[i] ? dir_q[i] : 1'b1;
            assign pin_out[i] = io_role[i] ? out_q[i] : dtr_val;
        end else begin : g_in
            assign pin_oe[i]  = io_role[i] ? dir_q[i] : 1'b0;
            assign pin_out[i] = io_role[i] ? out_q[i] : 1'b0;
        end
    end

    gpio_chg_modem u_mdm_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst),
        .mode      (ctrl_q[CTRL_MDM_A]),
        .lines     ({lvl[HALF+2], lvl[HALF+3], lvl[HALF]}),
        .rd_msr    (rd_msr_a),
        .msr       (msr_a),
        .delta_any (dlt_a)
    );

    gpio_chg_modem u_mdm_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst),
        .mode      (ctrl_q[CTRL_MDM_B]),
        .lines     ({lvl[2], lvl[3], lvl[0]}),
        .rd_msr    (rd_msr_b),
        .msr       (msr_b),
        .delta_any (dlt_b)
    );

    // outputs
    always_comb begin
        unique case (addr)
            A_DIR:   rdata = dir_q;
            A_PINS:  rdata = rdv_w;
            A_CHGEN: rdata = chgen_q;
            A_CTRL:  rdata = {4'b0000, srst, ctrl_q};
            A_MSR_A: rdata = msr_a;
            A_MSR_B: rdata = msr_b;
            A_MDM_A: rdata = {4'b0000, mdm_a_q[1], 2'b00, mdm_a_q[0]};
            A_MDM_B: rdata = {4'b0000, mdm_b_q[1], 2'b00, mdm_b_q[0]};
            default: rdata = 8'h00;
        endcase
        irq = (|(pend_w & chgen_q)) | (dlt_a & mdm_a_q[1]) | (dlt_b & mdm_b_q[1]);
    end
endmodule

// File: rtl/gpio_chg_checker.sv
module gpio_chg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic       irq,
    input logic       srst,
    input logic [7:0] dir_q,
    input logic [7:0] chgen_q,
    input logic [2:0] ctrl_q,
    input logic       msi_a,
    input logic       msi_b,
    input logic [7:0] pend_w
);
    // R3: nothing enabled means no interrupt
    assert_irq_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chgen_q == 8'h00 && !msi_a && !msi_b) |-> !irq);

    // R5: latched pending flags hold without a state read or a write
    assert_latched_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[0] && !(rd_en && addr == 3'd1) && !wr_en && !srst)
        |=> ((pend_w & $past(pend_w)) == $past(pend_w)));

    // R10: soft reset runs one clearing cycle, then all state is zero
    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd3 && wdata[3] && !srst)
        |=> srst ##1 (!srst && dir_q == 8'h00 && chgen_q == 8'h00 && ctrl_q == 3'b000));

    // R7: modem-role nibbles never hold pin-change flags
    assert_modem_quiet_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1] && $past(ctrl_q[1])) |-> (pend_w[7:4] == 4'b0000));

    assert_modem_quiet_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[2] && $past(ctrl_q[2])) |-> (pend_w[3:0] == 4'b0000));

    // R3: interrupt line is always a known value
    assert_irq_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(irq));
endmodule

bind gpio_chg_ctl gpio_chg_checker i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq     (irq),
    .srst    (srst),
    .dir_q   (dir_q),
    .chgen_q (chgen_q),
    .ctrl_q  (ctrl_q),
    .msi_a   (mdm_a_q[1]),
    .msi_b   (mdm_b_q[1]),
    .pend_w  (pend_w)
);

// File: tb/test_gpio_chg_ctl.sv
module test_gpio_chg_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_ref, m_pend, m_held, m_dir, m_en;
    logic       m_latch;

    always #5 clk = ~clk;

    gpio_chg_ctl i_gpio_chg_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq     (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // settled-level model of pin capture
    function automatic logic [7:0] exp_read(input logic [7:0] pins, input logic [7:0] pend,
                                            input logic [7:0] held, input logic latch);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = (latch && pend[i]) ? held[i] : pins[i];
        return r;
    endfunction

    task automatic model_step(input logic [7:0] pins);
        for (int i = 0; i < 8; i++) begin
            if (!m_dir[i]) begin
                if (!m_latch) begin
                    m_pend[i] = (pins[i] != m_ref[i]);
                end else if (!m_pend[i] && pins[i] != m_ref[i]) begin
                    m_pend[i] = 1'b1;
                    m_held[i] = pins[i];
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5eed_1234));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reg after reset", d, 8'h00);
        end
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
        chk("R1 pin_oe after reset", pin_oe, 8'h00);

        // R2: I/O outputs
        wr(3'd0, 8'hF0);
        wr(3'd1, 8'hA5);
        chk("R2 pin_oe", pin_oe, 8'hF0);
        chk("R2 pin_out", pin_out, 8'hA5);

        // R11 latency and R3 detection
        wr(3'd0, 8'h00);
        wr(3'd2, 8'hFF);
        @(negedge clk); pin_in[0] = 1'b1;
        idle(2);
        chk("R11 irq after two edges", {7'b0, irq}, 8'h00);
        idle(1);
        chk("R11 irq after three edges", {7'b0, irq}, 8'h01);
        rd(3'd1, d);
        chk("R4 transparent read value", d, 8'h01);
        chk("R4 irq cleared by read", {7'b0, irq}, 8'h00);

        // R3: output pins never pend
        wr(3'd0, 8'h01);
        @(negedge clk); pin_in[0] = 1'b0;
        idle(5);
        chk("R3 output pin no irq", {7'b0, irq}, 8'h00);
        wr(3'd0, 8'h00);
        idle(3);
        chk("R3 back to input no irq", {7'b0, irq}, 8'h00);

        // R3: enable mask
        wr(3'd2, 8'h00);
        @(negedge clk); pin_in[1] = 1'b1;
        idle(5);
        chk("R3 masked pin no irq", {7'b0, irq}, 8'h00);
        wr(3'd2, 8'h02);
        chk("R3 enabling pending pin", {7'b0, irq}, 8'h01);
        rd(3'd1, d);
        wr(3'd2, 8'hFF);

        // R4: transparent withdrawal
        @(negedge clk); pin_in[2] = 1'b1;
        idle(5);
        chk("R4 transparent irq set", {7'b0, irq}, 8'h01);
        @(negedge clk); pin_in[2] = 1'b0;
        idle(5);
        chk("R4 return clears irq", {7'b0, irq}, 8'h00);

        // R5: latched hold
        wr(3'd3, 8'h01);
        @(negedge clk); pin_in[3] = 1'b1;
        idle(5);
        chk("R5 latched irq set", {7'b0, irq}, 8'h01);
        @(negedge clk); pin_in[3] = 1'b0;
        idle(5);
        chk("R5 return keeps irq", {7'b0, irq}, 8'h01);
        rd(3'd1, d);
        chk("R5 read frozen level", d, 8'h0A);
        chk("R5 read clears irq", {7'b0, irq}, 8'h00);
        wr(3'd3, 8'h00);

        // R6: change on the read edge
        @(negedge clk); pin_in[4] = 1'b1;
        idle(5);
        @(negedge clk); pin_in[4] = 1'b0;
        @(negedge clk); rd_en = 1'b1; addr = 3'd1;
        @(negedge clk); rd_en = 1'b0;
        chk("R6 change on read edge keeps irq", {7'b0, irq}, 8'h01);
        idle(3);
        rd(3'd1, d);
        chk("R6 later read clears", {7'b0, irq}, 8'h00);

        // random phase: R3 R4 R5
        for (int blk = 0; blk < 8; blk++) begin
            rd(3'd1, d);
            m_dir   = 8'($urandom) & 8'($urandom);
            m_en    = 8'($urandom) | 8'($urandom);
            m_latch = 1'($urandom);
            wr(3'd0, m_dir);
            wr(3'd2, m_en);
            wr(3'd3, {7'b0, m_latch});
            idle(2);
            m_ref  = pin_in;
            m_pend = 8'h00;
            m_held = 8'h00;
            for (int s = 0; s < 30; s++) begin
                logic [7:0] np;
                np = pin_in ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
                @(negedge clk); pin_in = np;
                idle(5);
                model_step(np);
                chk(m_latch ? "R5 random irq" : "R4 random irq", {7'b0, irq},
                    {7'b0, |(m_pend & m_en)});
                if (($urandom % 3) == 0) begin
                    rd(3'd1, d);
                    chk(m_latch ? "R5 random read" : "R4 random read", d,
                        exp_read(np, m_pend, m_held, m_latch));
                    m_pend = 8'h00;
                    m_ref  = np;
                    chk("R3 irq after random read", {7'b0, irq}, 8'h00);
                end
            end
        end

        // modem role: R7 R8 R9
        rd(3'd1, d);
        wr(3'd3, 8'h00);
        @(negedge clk); pin_in = 8'h00;
        idle(4);
        rd(3'd1, d);
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'h02);
        chk("R7 channel A oe", pin_oe, 8'h2F);
        chk("R7 channel A out", pin_out, 8'h0F);
        wr(3'd6, 8'h01);
        chk("R9 DTR A driven", pin_out, 8'h2F);
        rd(3'd6, d);
        chk("R9 cfg A readback", d, 8'h01);
        wr(3'd0, 8'h00);
        @(negedge clk); pin_in[6] = 1'b1;
        idle(5);
        chk("R7 modem change no irq without modem enable", {7'b0, irq}, 8'h00);
        rd(3'd4, d);
        chk("R8 CD level and delta", d, 8'h88);
        rd(3'd4, d);
        chk("R8 read clears delta", d, 8'h80);
        rd(3'd5, d);
        chk("R8 channel B in I/O reads 0", d, 8'h00);
        wr(3'd6, 8'h09);
        @(negedge clk); pin_in[7] = 1'b1;
        idle(5);
        chk("R9 modem irq enabled", {7'b0, irq}, 8'h01);
        rd(3'd4, d);
        chk("R8 RI delta", d, 8'hC4);
        chk("R9 irq cleared by status read", {7'b0, irq}, 8'h00);

        wr(3'd3, 8'h06);
        chk("R7 both channels oe", pin_oe, 8'h22);
        wr(3'd7, 8'h08);
        @(negedge clk); pin_in[0] = 1'b1;
        idle(5);
        chk("R9 channel B irq", {7'b0, irq}, 8'h01);
        rd(3'd5, d);
        chk("R8 DSR level and delta", d, 8'h22);
        chk("R9 DTR B idle low", {7'b0, pin_out[1]}, 8'h00);

        // R10: soft reset
        @(negedge clk); wr_en = 1'b1; addr = 3'd3; wdata = 8'h0F;
        @(negedge clk); wr_en = 1'b0;
        #1 chk("R10 reset bit visible", rdata & 8'h08, 8'h08);
        idle(1);
        rd(3'd3, d);
        chk("R10 ctrl after soft reset", d, 8'h00);
        rd(3'd6, d);
        chk("R10 modem cfg cleared", d, 8'h00);
        chk("R10 pin_oe cleared", pin_oe, 8'h00);
        wr(3'd3, 8'hF1);
        rd(3'd3, d);
        chk("R10 reserved bits read 0", d, 8'h01);
        wr(3'd3, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule